// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns two static rates, the system clock frequency and the requested bus frequency (both in hertz), into the SCL high-phase and low-phase lengths in system clock cycles that an I2C master needs. It then runs a phase counter that toggles an internal SCL level, with one-cycle strobes at each SCL edge and a strobe that marks when SDA may change after SCL has fallen. A bit-level engine consumes these strobes. That engine is outside this block, as are clock stretching by slaves and any data FIFOs.

Requested rates above half the system clock are reduced to half the system clock. At or below 100 kHz the period is split evenly between high and low. Above 100 kHz the high phase gets 36 % and the low phase 64 % of the period. Every division truncates toward zero. Each count is then forced into the range 1 to the largest value the count width holds.

The configuration is captured only while `en` is low, so the inputs may change freely during a transfer. There is no data stream through this block, so every pin is a plain level or strobe and none has a handshake.

Top module: `scl_timing_gen`

## Requirements
- R1: A requested frequency greater than floor(sys_clk_hz / 2) is replaced by floor(sys_clk_hz / 2) before the counts are computed. A requested frequency equal to that value is used unchanged.
- R2: When the effective frequency f is at most 100000, both hi_cnt and lo_cnt equal floor(sys_clk_hz / (2·f)).
- R3: When f is above 100000, hi_cnt = floor(sys_clk_hz·36 / (f·100)) and lo_cnt = floor(sys_clk_hz·64 / (f·100)).
- R4: A count that computes to 0 is output as 1.
- R5: A count larger than 2^CNT_W − 1 is output as 2^CNT_W − 1. A requested frequency of 0 is treated as 1 Hz.
- R6: One clock edge after `en` is first seen high, scl_o starts a high phase. From then on scl_o stays high for exactly hi_cnt cycles and low for exactly lo_cnt cycles, alternating.
- R7: scl_fall is high for one cycle, the first cycle in which scl_o is 0 after being 1. scl_rise is high for one cycle, the first cycle in which scl_o is 1 after being 0. The two strobes are never high together.
- R8: sda_upd pulses exactly once per low phase, in the low-phase cycle with 0-based index min(10, lo_cnt − 1) counted from the first low cycle.
- R9: While `en` is low, scl_o is 1 from the next edge onward, and scl_rise, scl_fall and sda_upd are 0.
- R10: hi_cnt and lo_cnt follow the inputs one edge after each edge at which `en` is low. They hold their value while `en` is high, whatever the inputs do.
- R11: During reset, hi_cnt and lo_cnt are 1, scl_o is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the SCL phase counter; low allows the configuration to be captured |
| sys_clk_hz | input | RATE_W | System clock rate in Hz (static) |
| bus_hz | input | RATE_W | Requested SCL rate in Hz (static) |
| hi_cnt | output | CNT_W | Captured SCL high-phase length in cycles |
| lo_cnt | output | CNT_W | Captured SCL low-phase length in cycles |
| scl_o | output | 1 | Internal SCL level, 1 = released |
| scl_rise | output | 1 | One-cycle strobe at an SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe at an SCL falling edge |
| sda_upd | output | 1 | One-cycle strobe: SDA may change now |

## Verification
Some properties are checked on every cycle. The captured counts never fall to zero and stay frozen while running. The block stays released and silent when disabled. Rise and fall strobes never overlap and match the actual edges of scl_o. sda_upd only fires while SCL is low. Other behaviour is shown only by the bench's scenarios: the numeric results of the clamp, the even split, the 36/64 split, truncation, floor and ceiling, the measured length of each phase, the exact position of the SDA strobe, and the freezing of the configuration while running.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam int unsigned WIDE_W = 64;

  // Clamp a computed phase length into [1, maxv].
  function automatic logic [WIDE_W-1:0] fit_cnt(input logic [WIDE_W-1:0] q,
                                                input logic [WIDE_W-1:0] maxv);
    if (q == '0)       return {{(WIDE_W-1){1'b0}}, 1'b1};
    else if (q > maxv) return maxv;
    else               return q;
  endfunction
endpackage

// File: rtl/scl_div_calc.sv
module scl_div_calc
  import scl_timing_pkg::*;
#(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STD_MAX_HZ = 100000,
  parameter int unsigned HI_PART    = 36,
  parameter int unsigned LO_PART    = 64,
  parameter int unsigned FULL_PART  = 100
) (
  input  logic [RATE_W-1:0] sys_hz,
  input  logic [RATE_W-1:0] req_hz,
  output logic [CNT_W-1:0]  hi_val,
  output logic [CNT_W-1:0]  lo_val
);
  localparam logic [WIDE_W-1:0] CNT_MAX = WIDE_W'((64'd1 << CNT_W) - 64'd1);
  localparam logic [WIDE_W-1:0] STD_LIM = WIDE_W'(STD_MAX_HZ);

  logic [WIDE_W-1:0] sys_w, req_w, half_w, fcap, feff;
  logic [WIDE_W-1:0] q_hi, q_lo, fit_hi, fit_lo;

  always_comb begin
    sys_w  = WIDE_W'(sys_hz);
    req_w  = (req_hz == '0) ? 64'd1 : WIDE_W'(req_hz);
    half_w = sys_w >> 1;
    fcap   = (half_w == '0) ? 64'd1 : half_w;
    feff   = (req_w > fcap) ? fcap : req_w;
    if (feff <= STD_LIM) begin
      q_hi = sys_w / (feff << 1);
      q_lo = q_hi;
    end else begin
      q_hi = (sys_w * WIDE_W'(HI_PART)) / (feff * WIDE_W'(FULL_PART));
      q_lo = (sys_w * WIDE_W'(LO_PART)) / (feff * WIDE_W'(FULL_PART));
    end
    fit_hi = fit_cnt(q_hi, CNT_MAX);
    fit_lo = fit_cnt(q_lo, CNT_MAX);
    hi_val = fit_hi[CNT_W-1:0];
    lo_val = fit_lo[CNT_W-1:0];
  end
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= CNT_W'(1);
      lo_q <= CNT_W'(1);
    end else if (!en) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  // R4: captured lengths never collapse to zero
  a_r4_nonzero_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q != '0) && (lo_q != '0));

  // R10: configuration frozen while running
  a_r10_frozen_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned HOLD_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             scl_o,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             sda_upd
);
  localparam int unsigned      IDX_W  = $clog2(HOLD_CYC + 2);
  localparam logic [IDX_W-1:0] HOLD_V = IDX_W'(HOLD_CYC);
  localparam logic [IDX_W-1:0] DONE_V = IDX_W'(HOLD_CYC + 1);

  logic             running, phase_hi;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] low_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      phase_hi <= 1'b1;
      cnt      <= '0;
      low_idx  <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else if (!en) begin
      running  <= 1'b0;
      phase_hi <= 1'b1;
      cnt      <= '0;
      low_idx  <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else if (!running) begin
      running  <= 1'b1;
      phase_hi <= 1'b1;
      cnt      <= hi_len - 1'b1;
      low_idx  <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else if (cnt == '0) begin
      phase_hi <= !phase_hi;
      cnt      <= phase_hi ? (lo_len - 1'b1) : (hi_len - 1'b1);
      low_idx  <= '0;
      scl_rise <= !phase_hi;
      scl_fall <= phase_hi;
    end else begin
      cnt      <= cnt - 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (low_idx != DONE_V) low_idx <= low_idx + 1'b1;
    end
  end

  assign scl_o   = phase_hi;
  assign sda_upd = running && !phase_hi &&
                   ((low_idx == HOLD_V) || ((cnt == '0) && (low_idx < HOLD_V)));

  // R9: released and silent while disabled
  a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !scl_rise && !scl_fall && !sda_upd));

  // R7: strobes exclusive and tied to real edges
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));
  a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_o && !$past(scl_o)));
  a_r7_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_o && $past(scl_o)));

  // R8: SDA strobe only during the low phase
  a_r8_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd |-> !scl_o);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STD_MAX_HZ = 100000,
  parameter int unsigned HOLD_CYC   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] sys_clk_hz,
  input  logic [RATE_W-1:0] bus_hz,
  output logic [CNT_W-1:0]  hi_cnt,
  output logic [CNT_W-1:0]  lo_cnt,
  output logic              scl_o,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              sda_upd
);
  logic [CNT_W-1:0] hi_calc, lo_calc;

  scl_div_calc #(
    .RATE_W(RATE_W), .CNT_W(CNT_W), .STD_MAX_HZ(STD_MAX_HZ),
    .HI_PART(36), .LO_PART(64), .FULL_PART(100)
  ) u_calc (
    .sys_hz(sys_clk_hz), .req_hz(bus_hz), .hi_val(hi_calc), .lo_val(lo_calc)
  );

  scl_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hi_in(hi_calc), .lo_in(lo_calc), .hi_q(hi_cnt), .lo_q(lo_cnt)
  );

  scl_phase_gen #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .hi_len(hi_cnt), .lo_len(lo_cnt),
    .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_upd(sda_upd)
  );
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
  localparam int NV = 10;
  localparam logic [31:0] V_SYS [NV] = '{32'd50_000_000, 32'd50_000_000, 32'd50_000_000,
    32'd50_000_000, 32'd1_000_000, 32'd10, 32'd24_000_000, 32'd4_000_000_000,
    32'd1000, 32'd3_333_333};
  localparam logic [31:0] V_BUS [NV] = '{32'd100_000, 32'd400_000, 32'd1_000_000,
    32'd100_001, 32'd900_000, 32'd5, 32'd3_000, 32'd1, 32'd0, 32'd1_000_000};
  localparam logic [15:0] V_HI  [NV] = '{16'd250, 16'd45, 16'd18, 16'd179, 16'd1,
    16'd1, 16'd4000, 16'd65535, 16'd500, 16'd1};
  localparam logic [15:0] V_LO  [NV] = '{16'd250, 16'd80, 16'd32, 16'd319, 16'd1,
    16'd1, 16'd4000, 16'd65535, 16'd500, 16'd2};
  localparam bit V_RUN [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] sys_clk_hz = 32'd0;
  logic [31:0] bus_hz = 32'd0;
  logic [15:0] hi_cnt, lo_cnt;
  logic scl_o, scl_rise, scl_fall, sda_upd;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sys_clk_hz(sys_clk_hz), .bus_hz(bus_hz),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .scl_o(scl_o), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_upd(sda_upd)
  );

  function automatic string req_of(input int i);
    case (i)
      0, 5, 6: return "R2";
      4:       return "R1_R4";
      7, 8:    return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [31:0] s, input logic [31:0] b);
    @(negedge clk);
    en = 1'b0;
    sys_clk_hz = s;
    bus_hz = b;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // Enable, then measure one full low phase and the following high phase (R6, R7, R8).
  task automatic measure(input int exp_h, input int exp_l);
    int lcnt, hcnt, sda_pos, sda_n, guard;
    lcnt = 0; hcnt = 0; sda_pos = -1; sda_n = 0; guard = 0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R6", "scl high after enable", scl_o, 1);
    while (scl_o && guard < 70000) begin @(negedge clk); guard++; end
    chk("R7", "fall strobe at first low cycle", scl_fall, 1);
    while (!scl_o && guard < 70000) begin
      if (sda_upd) begin sda_n++; sda_pos = lcnt; end
      lcnt++; guard++;
      @(negedge clk);
    end
    chk("R7", "rise strobe at first high cycle", scl_rise, 1);
    while (scl_o && guard < 70000) begin hcnt++; guard++; @(negedge clk); end
    chk("R6", "low phase length", lcnt, exp_l);
    chk("R6", "high phase length", hcnt, exp_h);
    chk("R8", "sda strobes per low phase", sda_n, 1);
    chk("R8", "sda strobe index", sda_pos, (exp_l - 1 < 10) ? exp_l - 1 : 10);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "hi_cnt in reset", hi_cnt, 1);
    chk("R11", "lo_cnt in reset", lo_cnt, 1);
    chk("R11", "scl_o in reset", scl_o, 1);
    chk("R11", "strobes in reset", {scl_rise, scl_fall, sda_upd}, 0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      load_cfg(V_SYS[i], V_BUS[i]);
      chk(req_of(i), "hi_cnt", hi_cnt, V_HI[i]);
      chk(req_of(i), "lo_cnt", lo_cnt, V_LO[i]);
      if (V_RUN[i]) measure(V_HI[i], V_LO[i]);
    end

    // R1 boundary: request exactly half the clock is not reduced (10 Hz clock, 5 Hz ask -> 1/1)
    // versus one above half on a larger clock: 2 MHz clock, 1_000_001 Hz -> clamp 1 MHz -> 36/64 of 2
    load_cfg(32'd2_000_000, 32'd1_000_001);
    chk("R1", "clamped hi_cnt", hi_cnt, 1);
    chk("R1", "clamped lo_cnt", lo_cnt, 1);
    load_cfg(32'd200_000_000, 32'd1_000_000);
    chk("R1", "unclamped hi_cnt", hi_cnt, 72);
    chk("R1", "unclamped lo_cnt", lo_cnt, 128);

    // R10: inputs changed while running are ignored
    load_cfg(V_SYS[1], V_BUS[1]);
    @(negedge clk);
    en = 1'b1;
    sys_clk_hz = V_SYS[2];
    bus_hz = V_BUS[2];
    repeat (5) @(negedge clk);
    chk("R10", "hi_cnt frozen while running", hi_cnt, 45);
    chk("R10", "lo_cnt frozen while running", lo_cnt, 80);
    // R9: disable in mid low phase
    while (scl_o) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R9", "scl released when disabled", scl_o, 1);
      chk("R9", "strobes quiet when disabled", {scl_rise, scl_fall, sda_upd}, 0);
      @(negedge clk);
    end
    chk("R10", "hi_cnt captured after disable", hi_cnt, 18);
    chk("R10", "lo_cnt captured after disable", lo_cnt, 32);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule